// File: doc/BRIEF.md
# Port-Adapter Interrupt Aggregator

This block gathers network interrupt requests from up to seven adapter bays. Each bay has up to eight ports. A CPU sees the requests through a small register window and receives one combined network interrupt line.

Each bay owns one byte-wide field inside one of two 32-bit pending words. The placement follows a fixed map that is deliberately not in bay order. Each pending word has its own CPU-writable enable word, and the network line is raised whenever any pending bit is also enabled.

Two other sources share the window:

- **Hot-swap event log.** Pulses record card insertion or removal per slot, plus a memory-fault flag. Software clears the log by writing ones to the bits it wants cleared. Any access to the log lowers the event interrupt line.
- **Card-management view.** A read-only view of the bays that hold a card. Any access to it lowers the management interrupt line.

Top module: `pa_irq_aggr`

## Requirements
- R1: Bay fields are placed as follows: bays 0, 1, 4 and 3 in pending word 0 at bit bases 0, 8, 16 and 24; bays 2, 6 and 5 in pending word 1 at bit bases 8, 16 and 24. Port p of a bay maps to bit base+p.
- R2: A set strobe sets the addressed pending bit and a clear strobe clears it, both at the next clock edge. When both strobes hit the same bit in one cycle, the bit ends up set.
- R3: `net_irq` equals OR-reduce((pend0 AND en0) OR (pend1 AND en1)). It is registered, so it follows a strobe or an enable write by exactly one clock edge.
- R4: Pending word 0 reads at addresses 0x10–0x13 and pending word 1 at 0x18–0x1B; writes there are ignored. Enable word 0 is read/write at 0x20 and enable word 1 at 0x28.
- R5: The event log at 0x70 is 8 bits wide and reads back zero-extended. A pulse on `evt_pulse[k]` for k in 1..7 sets bit k: bits 1–6 are slots 1–6 and bit 7 is a memory fault. Bit 0 always reads 0. A write clears every bit written as 1. A pulse arriving in the same cycle as a clearing write keeps its bit set.
- R6: `oir_irq` rises one edge after any pulse on `evt_pulse[7:1]`. It falls one edge after any read or write at 0x70, unless a new pulse arrives in that same cycle.
- R7: A read at 0x40 returns two adjacent bits for each bay 1–6 that has `bay_present` set. The pair starts at bit 9 for bay 1, 13 for bay 2, 17 for bay 4, 21 for bay 6, 25 for bay 3 and 29 for bay 5. Bay 0 contributes nothing.
- R8: `mgmt_irq` rises one edge after a `mgmt_req` pulse. It falls one edge after any read or write at 0x40, unless `mgmt_req` is high in that same cycle.
- R9: Reads of any other address return zero, and writes to them change no register.
- R10: A strobe whose bay index is 7 changes neither pending word.
- R11: A synchronous active-high reset clears both pending words, both enable words, the event log and all three interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| set_vld | input | 1 | Set strobe for one pending bit |
| set_bay | input | 3 | Bay index for the set strobe |
| set_port | input | 3 | Port index for the set strobe |
| clr_vld | input | 1 | Clear strobe for one pending bit |
| clr_bay | input | 3 | Bay index for the clear strobe |
| clr_port | input | 3 | Port index for the clear strobe |
| bay_present | input | 7 | Card present, one bit per bay |
| evt_pulse | input | 8 | Hot-swap and fault event pulses; bit 0 is unused |
| mgmt_req | input | 1 | Card-management interrupt request pulse |
| net_irq | output | 1 | Combined network interrupt |
| mgmt_irq | output | 1 | Card-management interrupt |
| oir_irq | output | 1 | Hot-swap event interrupt |

## Verification
The bench walks every bay through its own field and reads back both pending words. A design that placed bays in index order would land the bit in the wrong word or the wrong byte. It drives a set and a clear onto the same bit in one cycle, and a log pulse together with a clearing write; a design that lets the clear win would lose an interrupt. It samples `net_irq` both before and after the edge that follows a strobe, which catches an output one cycle late or one that is not registered. It also writes to the read-only pending window and to unmapped addresses, uses bay index 7, and checks that no register changes.

// File: rtl/pa_irq_pkg.sv
package pa_irq_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int N_WORDS = 2;
    localparam int N_BAYS  = 7;
    localparam int BAY_W   = 3;
    localparam int PORT_W  = 3;
    localparam int EVT_W   = 8;
    localparam int POS_W   = $clog2(DATA_W);

    localparam logic [EVT_W-1:0] EVT_LIVE = 8'hFE;

    localparam logic [ADDR_W-1:0] A_PEND0 = 8'h10;
    localparam logic [ADDR_W-1:0] A_PEND1 = 8'h18;
    localparam logic [ADDR_W-1:0] A_EN0   = 8'h20;
    localparam logic [ADDR_W-1:0] A_EN1   = 8'h28;
    localparam logic [ADDR_W-1:0] A_MGMT  = 8'h40;
    localparam logic [ADDR_W-1:0] A_EVT   = 8'h70;

    typedef logic [N_WORDS-1:0][DATA_W-1:0] word_pair_t;

    typedef struct packed {
        word_pair_t       pend;
        word_pair_t       en;
        logic [EVT_W-1:0] evt;
        logic             net_irq;
        logic             mgmt_irq;
        logic             oir_irq;
    } agg_state_t;

    // Which pending word a bay lives in
    function automatic logic bay_word(input logic [BAY_W-1:0] bay);
        case (bay)
            3'd2, 3'd5, 3'd6: bay_word = 1'b1;
            default:          bay_word = 1'b0;
        endcase
    endfunction

    // Bit base of a bay's port field inside its word
    function automatic logic [POS_W-1:0] bay_base(input logic [BAY_W-1:0] bay);
        case (bay)
            3'd1, 3'd2: bay_base = 5'd8;
            3'd4, 3'd6: bay_base = 5'd16;
            3'd3, 3'd5: bay_base = 5'd24;
            default:    bay_base = 5'd0;
        endcase
    endfunction

    // First of the two card-present bits of a bay in the management view
    function automatic logic [POS_W-1:0] card_base(input logic [BAY_W-1:0] bay);
        case (bay)
            3'd1:    card_base = 5'd9;
            3'd2:    card_base = 5'd13;
            3'd4:    card_base = 5'd17;
            3'd6:    card_base = 5'd21;
            3'd3:    card_base = 5'd25;
            3'd5:    card_base = 5'd29;
            default: card_base = 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/pa_irq_bitsel.sv
module pa_irq_bitsel
    import pa_irq_pkg::*;
#(
    parameter int NB = N_BAYS
) (
    input  logic              vld,
    input  logic [BAY_W-1:0]  bay,
    input  logic [PORT_W-1:0] port,
    output word_pair_t        hit
);

    logic [POS_W-1:0] pos;

    always_comb begin
        hit = '0;
        pos = bay_base(bay) + POS_W'(port);
        if (vld && (int'(bay) < NB)) begin
            hit[bay_word(bay)][pos] = 1'b1;
        end
    end

endmodule

// File: rtl/pa_card_view.sv
module pa_card_view
    import pa_irq_pkg::*;
#(
    parameter int NB = N_BAYS
) (
    input  logic [NB-1:0]     present,
    output logic [DATA_W-1:0] view
);

    always_comb begin
        view = '0;
        for (int b = 1; b < NB; b++) begin
            if (present[b]) begin
                view[card_base(BAY_W'(b)) +: 2] = 2'b11;
            end
        end
    end

endmodule

// File: rtl/pa_irq_aggr.sv
module pa_irq_aggr
    import pa_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              set_vld,
    input  logic [BAY_W-1:0]  set_bay,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_vld,
    input  logic [BAY_W-1:0]  clr_bay,
    input  logic [PORT_W-1:0] clr_port,
    input  logic [N_BAYS-1:0] bay_present,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              mgmt_req,
    output logic              net_irq,
    output logic              mgmt_irq,
    output logic              oir_irq
);

    localparam int WSEL_W = ADDR_W - 2;

    agg_state_t        st_d, st_q;
    word_pair_t        set_hit, clr_hit;
    logic [DATA_W-1:0] card_word;

    logic              sel_pend0, sel_pend1, acc_evt, acc_mgmt;
    logic [EVT_W-1:0]  evt_wipe;
    logic [EVT_W-1:0]  evt_new;

    pa_irq_bitsel #(.NB(N_BAYS)) u_set_sel (
        .vld  (set_vld),
        .bay  (set_bay),
        .port (set_port),
        .hit  (set_hit)
    );

    pa_irq_bitsel #(.NB(N_BAYS)) u_clr_sel (
        .vld  (clr_vld),
        .bay  (clr_bay),
        .port (clr_port),
        .hit  (clr_hit)
    );

    pa_card_view #(.NB(N_BAYS)) u_card (
        .present (bay_present),
        .view    (card_word)
    );

    // Address decode
    always_comb begin
        sel_pend0 = (bus_addr[ADDR_W-1:2] == A_PEND0[ADDR_W-1:2]);
        sel_pend1 = (bus_addr[ADDR_W-1:2] == A_PEND1[ADDR_W-1:2]);
        acc_evt   = (bus_rd || bus_wr) && (bus_addr == A_EVT);
        acc_mgmt  = (bus_rd || bus_wr) && (bus_addr == A_MGMT);
        evt_wipe  = (bus_wr && bus_addr == A_EVT) ? bus_wdata[EVT_W-1:0] : '0;
        evt_new   = evt_pulse & EVT_LIVE;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        for (int w = 0; w < N_WORDS; w++) begin
            st_d.pend[w] = (st_q.pend[w] & ~clr_hit[w]) | set_hit[w];
        end
        if (bus_wr && bus_addr == A_EN0) st_d.en[0] = bus_wdata;
        if (bus_wr && bus_addr == A_EN1) st_d.en[1] = bus_wdata;
        st_d.evt      = ((st_q.evt & ~evt_wipe) | evt_new) & EVT_LIVE;
        st_d.oir_irq  = (|evt_new) || (st_q.oir_irq && !acc_evt);
        st_d.mgmt_irq = mgmt_req || (st_q.mgmt_irq && !acc_mgmt);
        st_d.net_irq  = |((st_d.pend[0] & st_d.en[0]) | (st_d.pend[1] & st_d.en[1]));
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_pend0)                bus_rdata = st_q.pend[0];
            else if (sel_pend1)           bus_rdata = st_q.pend[1];
            else if (bus_addr == A_EN0)   bus_rdata = st_q.en[0];
            else if (bus_addr == A_EN1)   bus_rdata = st_q.en[1];
            else if (bus_addr == A_MGMT)  bus_rdata = card_word;
            else if (bus_addr == A_EVT)   bus_rdata = DATA_W'(st_q.evt);
        end
    end

    assign net_irq  = st_q.net_irq;
    assign mgmt_irq = st_q.mgmt_irq;
    assign oir_irq  = st_q.oir_irq;

    logic unused_addr;
    assign unused_addr = ^bus_addr[WSEL_W+1:WSEL_W];

endmodule

// File: rtl/pa_irq_aggr_chk.sv
module pa_irq_aggr_chk
    import pa_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              set_vld,
    input logic [BAY_W-1:0]  set_bay,
    input logic [PORT_W-1:0] set_port,
    input logic              clr_vld,
    input logic [EVT_W-1:0]  evt_pulse,
    input logic              mgmt_req,
    input logic              net_irq,
    input logic              mgmt_irq,
    input logic              oir_irq,
    input agg_state_t        st_q
);

    logic             exp_w;
    logic [POS_W-1:0] exp_pos;

    always_comb begin
        exp_w   = bay_word(set_bay);
        exp_pos = bay_base(set_bay) + POS_W'(set_port);
    end

    // R3
    net_or_chk: assert property (@(posedge clk) disable iff (rst)
        net_irq == |((st_q.pend[0] & st_q.en[0]) | (st_q.pend[1] & st_q.en[1])));

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vld && set_bay != 3'd7) |=> st_q.pend[$past(exp_w)][$past(exp_pos)]);

    // R10
    bay7_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vld && set_bay == 3'd7 && !clr_vld) |=> $stable(st_q.pend));

    // R6
    oir_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr == A_EVT && evt_pulse[7:1] == 7'd0) |=> !oir_irq);

    // R8
    mgmt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr == A_MGMT && !mgmt_req) |=> !mgmt_irq);

    // R5
    evt_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_EVT) |-> (bus_rdata[0] == 1'b0 && bus_rdata[31:8] == 24'd0));

    // R9
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h48) |-> bus_rdata == '0);

endmodule

bind pa_irq_aggr pa_irq_aggr_chk chk_i (.*);

// File: tb/pa_irq_aggr_tb_top.sv
module pa_irq_aggr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        set_vld = 1'b0, clr_vld = 1'b0;
    logic [2:0]  set_bay = '0, set_port = '0, clr_bay = '0, clr_port = '0;
    logic [6:0]  bay_present = '0;
    logic [7:0]  evt_pulse = '0;
    logic        mgmt_req = 1'b0;
    logic        net_irq, mgmt_irq, oir_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pa_irq_aggr dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic strobe(input bit s, input bit c, input logic [2:0] b, input logic [2:0] p);
        set_vld = s; clr_vld = c; set_bay = b; clr_bay = b; set_port = p; clr_port = p;
        tick();
        set_vld = 1'b0; clr_vld = 1'b0;
    endtask

    // Independent bay placement model
    function automatic int word_of(input int b);
        return (b == 2 || b == 5 || b == 6) ? 1 : 0;
    endfunction

    function automatic int base_of(input int b);
        case (b)
            1, 2: return 8;
            4, 6: return 16;
            3, 5: return 24;
            default: return 0;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R11 net_irq", 32'(net_irq), 0);
        chk("R11 mgmt_irq", 32'(mgmt_irq), 0);
        chk("R11 oir_irq", 32'(oir_irq), 0);
        rd(8'h20, d); chk("R11 en0", d, 0);
        rd(8'h10, d); chk("R11 pend0", d, 0);
        rd(8'h70, d); chk("R11 evt", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d0, d1, e0, e1;
        for (int b = 0; b < 7; b++) begin
            strobe(1'b1, 1'b0, 3'(b), 3'(b));
            rd(8'h10 + 8'(b % 4), d0);
            rd(8'h18 + 8'(3 - (b % 4)), d1);
            e0 = (word_of(b) == 0) ? (32'd1 << (base_of(b) + b)) : 32'd0;
            e1 = (word_of(b) == 1) ? (32'd1 << (base_of(b) + b)) : 32'd0;
            chk("R1 word0 placement", d0, e0);
            chk("R1 word1 placement", d1, e1);
            strobe(1'b0, 1'b1, 3'(b), 3'(b));
            rd(8'h10, d0); rd(8'h18, d1);
            chk("R2 clear word0", d0, 0);
            chk("R2 clear word1", d1, 0);
        end
    endtask

    task automatic t_net();
        wr(8'h20, 32'h0000_0100);
        set_vld = 1'b1; set_bay = 3'd1; set_port = 3'd0;
        #1 chk("R3 before edge", 32'(net_irq), 0);
        tick(); set_vld = 1'b0;
        chk("R3 after set", 32'(net_irq), 1);
        strobe(1'b0, 1'b1, 3'd1, 3'd0);
        chk("R3 after clear", 32'(net_irq), 0);
        strobe(1'b1, 1'b0, 3'd5, 3'd2);
        chk("R3 unmasked word1", 32'(net_irq), 0);
        wr(8'h28, 32'h0400_0000);
        chk("R3 mask1 enables", 32'(net_irq), 1);
        wr(8'h28, 32'h0);
        chk("R3 mask1 disables", 32'(net_irq), 0);
        strobe(1'b0, 1'b1, 3'd5, 3'd2);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        strobe(1'b1, 1'b1, 3'd4, 3'd7);
        rd(8'h10, d); chk("R2 set wins", d, 32'h0080_0000);
        strobe(1'b0, 1'b1, 3'd4, 3'd7);
        rd(8'h10, d); chk("R2 clear alone", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        strobe(1'b1, 1'b0, 3'd3, 3'd1);
        wr(8'h12, 32'hFFFF_FFFF);
        wr(8'h1B, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R4 pend0 read-only", d, 32'h0200_0000);
        rd(8'h18, d); chk("R4 pend1 read-only", d, 0);
        wr(8'h28, 32'hA5A5_0F0F);
        rd(8'h28, d); chk("R4 en1 readback", d, 32'hA5A5_0F0F);
        rd(8'h20, d); chk("R4 en0 readback", d, 32'h0000_0100);
        wr(8'h28, 32'h0);
        strobe(1'b0, 1'b1, 3'd3, 3'd1);
        strobe(1'b1, 1'b0, 3'd7, 3'd0);
        rd(8'h10, d); chk("R10 bay7 word0", d, 0);
        rd(8'h18, d); chk("R10 bay7 word1", d, 0);
    endtask

    task automatic t_evt();
        logic [31:0] d;
        evt_pulse = 8'hFF; tick(); evt_pulse = '0;
        chk("R6 oir rises", 32'(oir_irq), 1);
        rd(8'h70, d); chk("R5 evt log", d, 32'h0000_00FE);
        chk("R6 read drops oir", 32'(oir_irq), 0);
        wr(8'h70, 32'h0000_0006);
        rd(8'h70, d); chk("R5 write-one clear", d, 32'h0000_00F8);
        evt_pulse = 8'h08;
        bus_addr = 8'h70; bus_wdata = 32'h08; bus_wr = 1'b1;
        tick(); bus_wr = 1'b0; evt_pulse = '0;
        chk("R6 pulse beats access", 32'(oir_irq), 1);
        rd(8'h70, d); chk("R5 pulse beats clear", d, 32'h0000_00F8);
        wr(8'h70, 32'hFF);
        chk("R6 write drops oir", 32'(oir_irq), 0);
        rd(8'h70, d); chk("R5 cleared", d, 0);
    endtask

    task automatic t_mgmt();
        logic [31:0] d;
        bay_present = 7'b1010011;
        rd(8'h40, d); chk("R7 card view", d, 32'h0066_0600);
        mgmt_req = 1'b1; tick(); mgmt_req = 1'b0;
        chk("R8 mgmt rises", 32'(mgmt_irq), 1);
        rd(8'h40, d);
        chk("R8 read drops mgmt", 32'(mgmt_irq), 0);
        bay_present = 7'b0101100;
        rd(8'h40, d); chk("R7 card view 2", d, 32'h2200_6000 | 32'h4400_0000 | 32'h0000_0000 | 32'h0200_0000 | 32'h0400_0000);
    endtask

    task automatic t_holes();
        logic [31:0] d;
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h48, d); chk("R9 hole 0x48", d, 0);
        rd(8'h24, d); chk("R9 hole 0x24", d, 0);
        rd(8'h20, d); chk("R9 en0 intact", d, 32'h0000_0100);
        rd(8'h28, d); chk("R9 en1 intact", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_net();
        t_collide();
        t_regs();
        t_evt();
        t_mgmt();
        t_holes();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule